// File: doc/BRIEF.md
# Streaming RGB565 to Luma Converter

This block turns a stream of packed 16-bit colour pixels into a stream of 8-bit brightness samples, discarding all colour information. Each incoming pixel holds a red field in its top five bits, a green field in the middle six bits and a blue field in the low five bits. Each field is widened to full 8-bit scale by bit replication. A weighted sum approximating 0.299 red, 0.587 green and 0.114 blue is then formed in fixed point, rounded to nearest and clamped to the output range. The resulting grayscale channel feeds later image-analysis stages such as filtering and background separation.

Pixels arrive with a valid strobe and optional start-of-line and start-of-frame markers. The block accepts one pixel per clock without back-pressure. Every result leaves exactly two cycles after its pixel, with its valid and markers delayed by the same amount. When no valid pixel emerges, the last luma value stays on the output.

Top module: `luma_stream_top`

## Requirements
- R1: Field expansion is done by replication. Red is inPixel[15:11] and blue is inPixel[4:0]; each is widened to 8 bits as {f[4:0], f[4:2]}. Green is inPixel[10:5] and is widened as {f[5:0], f[5:4]}. A pure full-scale red, green or blue pixel gives luma 77, 149 or 29.
- R2: The luma value equals (77*R8 + 150*G8 + 29*B8 + 128) >> 8, computed on the widened fields. It lies within 1 LSB of 0.299*R8 + 0.587*G8 + 0.114*B8.
- R3: The luma value never exceeds 255, and an all-ones pixel (0xFFFF) yields exactly 255.
- R4: outValid is high exactly two clock edges after inValid was sampled high, and the luma for that pixel appears in the same cycle.
- R5: In a cycle where outValid is low, outLuma keeps the value of the most recent valid result.
- R6: outSol and outSof repeat inSol and inSof two cycles later, but only for cycles in which the pixel was valid. They are never high while outValid is low.
- R7: While rstN is low, outValid, outSol and outSof are 0 and outLuma is 0. An asynchronous reset in mid-stream discards every pixel in flight.
- R8: Pixels presented on consecutive cycles each produce a result on consecutive cycles, in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pixel is valid this cycle |
| inPixel | input | 16 | Packed pixel: red [15:11], green [10:5], blue [4:0] |
| inSol | input | 1 | Input pixel starts a line |
| inSof | input | 1 | Input pixel starts a frame |
| outValid | output | 1 | outLuma holds a new result |
| outLuma | output | 8 | Grayscale result |
| outSol | output | 1 | Result starts a line |
| outSof | output | 1 | Result starts a frame |

## Verification
The bench uses the default parameters: 5/6/5 field widths, an 8-bit output, weights 77/150/29 and an 8-bit fraction. With these values an exhaustive sweep of all 65536 pixel codes fits well inside the run, so every rounding case of the weighted sum is compared against both the integer rule and the real-valued formula. Because the default weights sum to exactly 256, full-scale white lands on the clamp boundary at 255. The clamp therefore bounds the result but is never driven past it. Gaps in the valid strobe, markers raised on invalid cycles, and a reset in mid-stream exercise the hold, qualification and flush behaviour.

// File: rtl/luma_pkg.sv
package luma_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Number of register stages between a pixel and its luma result.
  localparam int PIPE_DEPTH = 2;

  // Load strobes from control to datapath, one per pipeline stage.
  typedef struct packed {
    logic loadMul;
    logic loadSum;
  } lumaStb_t;
endpackage

// File: rtl/luma_ctrl.sv
module luma_ctrl
  import luma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inSol,
  input  logic     inSof,
  output lumaStb_t stb,
  output logic     outValid,
  output logic     outSol,
  output logic     outSof
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [PIPE_DEPTH-1:0] validPipe;
  logic [PIPE_DEPTH-1:0] solPipe;
  logic [PIPE_DEPTH-1:0] sofPipe;

  // First stage: markers are qualified by the valid strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe[0] <= 1'b0;
      solPipe[0]   <= 1'b0;
      sofPipe[0]   <= 1'b0;
    end else begin
      validPipe[0] <= inValid;
      solPipe[0]   <= inValid & inSol;
      sofPipe[0]   <= inValid & inSof;
    end
  end

  // Remaining stages shift the sideband along.
  for (genvar s = 1; s < PIPE_DEPTH; s++) begin : gSide
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validPipe[s] <= 1'b0;
        solPipe[s]   <= 1'b0;
        sofPipe[s]   <= 1'b0;
      end else begin
        validPipe[s] <= validPipe[s-1];
        solPipe[s]   <= solPipe[s-1];
        sofPipe[s]   <= sofPipe[s-1];
      end
    end
  end

  always_comb begin
    stb.loadMul = inValid;
    stb.loadSum = validPipe[0];
  end

  assign outValid = validPipe[PIPE_DEPTH-1];
  assign outSol   = solPipe[PIPE_DEPTH-1];
  assign outSof   = sofPipe[PIPE_DEPTH-1];
endmodule

// File: rtl/luma_dp.sv
module luma_dp
  import luma_pkg::*;
#(
  parameter int R_W  = 5,
  parameter int G_W  = 6,
  parameter int B_W  = 5,
  parameter int Y_W  = 8,
  parameter int FRAC = 8,
  parameter int KR   = 77,
  parameter int KG   = 150,
  parameter int KB   = 29,
  localparam int PIX_W = R_W + G_W + B_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  lumaStb_t         stb,
  input  logic [PIX_W-1:0] pixel,
  output logic [Y_W-1:0]   luma
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int K_W    = FRAC + 1;
  localparam int PROD_W = Y_W + K_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic [PROD_W-1:0] KR_C  = PROD_W'(KR);
  localparam logic [PROD_W-1:0] KG_C  = PROD_W'(KG);
  localparam logic [PROD_W-1:0] KB_C  = PROD_W'(KB);
  localparam logic [SUM_W-1:0]  ROUND = SUM_W'(1) << (FRAC - 1);
  localparam logic [SUM_W-1:0]  MAXY  = SUM_W'((1 << Y_W) - 1);

  logic [R_W-1:0] rRaw;
  logic [G_W-1:0] gRaw;
  logic [B_W-1:0] bRaw;
  logic [Y_W-1:0] rExp, gExp, bExp;

  assign rRaw = pixel[PIX_W-1 -: R_W];
  assign gRaw = pixel[G_W+B_W-1 -: G_W];
  assign bRaw = pixel[B_W-1:0];

  // Widen each field to full scale by repeating its bits from the top.
  for (genvar i = 0; i < Y_W; i++) begin : gExpand
    assign rExp[Y_W-1-i] = rRaw[R_W-1-(i % R_W)];
    assign gExp[Y_W-1-i] = gRaw[G_W-1-(i % G_W)];
    assign bExp[Y_W-1-i] = bRaw[B_W-1-(i % B_W)];
  end

  // Stage 1: weighted products.
  logic [PROD_W-1:0] prodR, prodG, prodB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodR <= '0;
      prodG <= '0;
      prodB <= '0;
    end else if (stb.loadMul) begin
      prodR <= PROD_W'(rExp) * KR_C;
      prodG <= PROD_W'(gExp) * KG_C;
      prodB <= PROD_W'(bExp) * KB_C;
    end
  end

  // Stage 2: accumulate, round, drop the fraction, clamp.
  logic [SUM_W-1:0] sumAll;
  logic [SUM_W-1:0] sumShift;
  logic [Y_W-1:0]   satY;

  always_comb begin
    sumAll   = SUM_W'(prodR) + SUM_W'(prodG) + SUM_W'(prodB) + ROUND;
    sumShift = sumAll >> FRAC;
    satY     = (sumShift > MAXY) ? MAXY[Y_W-1:0] : sumShift[Y_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            luma <= '0;
    else if (stb.loadSum) luma <= satY;
  end
endmodule

// File: rtl/luma_stream_top.sv
module luma_stream_top
  import luma_pkg::*;
#(
  parameter int R_W  = 5,
  parameter int G_W  = 6,
  parameter int B_W  = 5,
  parameter int Y_W  = 8,
  parameter int FRAC = 8,
  parameter int KR   = 77,
  parameter int KG   = 150,
  parameter int KB   = 29
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [R_W+G_W+B_W-1:0]   inPixel,
  input  logic                     inSol,
  input  logic                     inSof,
  output logic                     outValid,
  output logic [Y_W-1:0]           outLuma,
  output logic                     outSol,
  output logic                     outSof
);
  timeunit 1ns;
  timeprecision 1ps;

  lumaStb_t stb;

  luma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSol    (inSol),
    .inSof    (inSof),
    .stb      (stb),
    .outValid (outValid),
    .outSol   (outSol),
    .outSof   (outSof)
  );

  luma_dp #(
    .R_W(R_W), .G_W(G_W), .B_W(B_W), .Y_W(Y_W),
    .FRAC(FRAC), .KR(KR), .KG(KG), .KB(KB)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .pixel (inPixel),
    .luma  (outLuma)
  );
endmodule

// File: rtl/luma_stream_chk.sv
module luma_stream_chk #(
  parameter int PIX_W = 16,
  parameter int Y_W   = 8
)(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [PIX_W-1:0] inPixel,
  input logic             inSol,
  input logic             inSof,
  input logic             outValid,
  input logic [Y_W-1:0]   outLuma,
  input logic             outSol,
  input logic             outSof
);
  timeunit 1ns;
  timeprecision 1ps;

  // Counts clock edges since reset release, saturating at 3.
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          warm <= '0;
    else if (warm != 3) warm <= warm + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2) |-> (outValid == $past(inValid, 2))); // R4

  AST_SOL_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    outSol |-> outValid); // R6

  AST_SOF_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((warm >= 1) && !outValid) |-> $stable(outLuma)); // R5

  AST_WHITE_TOP: assert property (@(posedge clk) disable iff (!rstN)
    ((warm >= 2) && outValid && $past(inValid && (inPixel == {PIX_W{1'b1}}), 2))
      |-> (outLuma == {Y_W{1'b1}})); // R3

  AST_BLACK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((warm >= 2) && outValid && $past(inValid && (inPixel == '0), 2))
      |-> (outLuma == '0)); // R2
endmodule

bind luma_stream_top luma_stream_chk #(
  .PIX_W(R_W + G_W + B_W),
  .Y_W  (Y_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inPixel  (inPixel),
  .inSol    (inSol),
  .inSof    (inSof),
  .outValid (outValid),
  .outLuma  (outLuma),
  .outSol   (outSol),
  .outSof   (outSof)
);

// File: tb/sim_luma_stream_top.sv
module sim_luma_stream_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inPixel = '0;
  logic        inSol = 1'b0;
  logic        inSof = 1'b0;
  logic        outValid;
  logic [7:0]  outLuma;
  logic        outSol;
  logic        outSof;

  always #5 clk = ~clk;

  luma_stream_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPixel(inPixel),
    .inSol(inSol), .inSof(inSof), .outValid(outValid), .outLuma(outLuma),
    .outSol(outSol), .outSof(outSof)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Vector table: {pixel, expected luma, tag index}; tag 1=R1, 2=R2, 3=R3.
  localparam int NVEC = 7;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'hF800, 8'd77,  8'd1},
    {16'h07E0, 8'd149, 8'd1},
    {16'h001F, 8'd29,  8'd1},
    {16'hFFFF, 8'd255, 8'd3},
    {16'h0000, 8'd0,   8'd2},
    {16'h8410, 8'd131, 8'd2},
    {16'h0821, 8'd6,   8'd2}
  };

  // Reference model of the pipeline, built from the requirements.
  logic        e1v = 0, e2v = 0, e1l = 0, e2l = 0, e1f = 0, e2f = 0;
  logic [7:0]  e1d = 0, e2d = 0, expData = 0;
  logic [15:0] e1p = 0, e2p = 0;
  string       e1t = "R2", e2t = "R2";

  function automatic logic [7:0] refLuma(input logic [15:0] p);
    logic [7:0] r8, g8, b8;
    int acc;
    r8 = {p[15:11], p[15:13]};
    g8 = {p[10:5], p[10:9]};
    b8 = {p[4:0], p[4:2]};
    acc = (77 * r8 + 150 * g8 + 29 * b8 + 128) >> 8;
    if (acc > 255) acc = 255;
    return 8'(acc);
  endfunction

  function automatic real realLuma(input logic [15:0] p);
    logic [7:0] r8, g8, b8;
    r8 = {p[15:11], p[15:13]};
    g8 = {p[10:5], p[10:9]};
    b8 = {p[4:0], p[4:2]};
    return 0.299 * r8 + 0.587 * g8 + 0.114 * b8;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkOut();
    real f, d;
    if (e2v) expData = e2d;
    chk(outValid == e2v, "R4", "outValid", int'(outValid), int'(e2v));
    chk(outLuma == expData, e2v ? e2t : "R5", "outLuma", int'(outLuma), int'(expData));
    chk(outSol == (e2v & e2l), "R6", "outSol", int'(outSol), int'(e2v & e2l));
    chk(outSof == (e2v & e2f), "R6", "outSof", int'(outSof), int'(e2v & e2f));
    if (e2v && outValid) begin
      f = realLuma(e2p);
      d = real'(outLuma) - f;
      if (d < 0.0) d = -d;
      chk(d <= 1.0, "R2", "float distance", int'(outLuma), int'(f));
    end
  endtask

  // One cycle: check outputs, advance model, drive next inputs.
  task automatic step(input logic rst, input logic v, input logic [15:0] p,
                      input logic sl, input logic sf, input logic [7:0] ex,
                      input string tag);
    @(negedge clk);
    checkOut();
    if (!rst) begin
      e1v = 0; e2v = 0; e1l = 0; e2l = 0; e1f = 0; e2f = 0; expData = 0;
    end else begin
      e2v = e1v; e2l = e1l; e2f = e1f; e2d = e1d; e2p = e1p; e2t = e1t;
      e1v = v; e1l = sl; e1f = sf; e1d = ex; e1p = p; e1t = tag;
    end
    rstN = rst; inValid = v; inPixel = p; inSol = sl; inSof = sf;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    report();
  end

  initial begin
    // R7: outputs cleared while reset is held.
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 16'hFFFF, 1'b1, 1'b1, 8'd0, "R7");
      chk(outValid == 0 && outLuma == 0 && outSol == 0 && outSof == 0,
          "R7", "reset outputs", int'(outLuma), 0);
    end

    // Table walked back to back (R1, R2, R3, R8).
    for (int i = 0; i < NVEC; i++) begin
      string t;
      t = (VEC[i][7:0] == 8'd1) ? "R1" : (VEC[i][7:0] == 8'd3) ? "R3" : "R8";
      step(1'b1, 1'b1, VEC[i][31:16], i == 0, i == 0, VEC[i][15:8], t);
    end

    // R5/R6: invalid cycles with markers raised; data must hold.
    for (int i = 0; i < 4; i++)
      step(1'b1, 1'b0, 16'h1234, 1'b1, 1'b1, 8'd0, "R5");
    step(1'b1, 1'b1, 16'h8410, 1'b1, 1'b0, 8'd131, "R6");
    step(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1, 8'd0, "R5");
    step(1'b1, 1'b1, 16'h0821, 1'b0, 1'b1, 8'd6, "R6");
    for (int i = 0; i < 3; i++)
      step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd0, "R5");

    // Exhaustive sweep with periodic gaps (R2).
    for (int c = 0; c < 65536; c++) begin
      if (c % 5 == 4) step(1'b1, 1'b0, 16'hA5A5, 1'b1, 1'b0, 8'd0, "R5");
      step(1'b1, 1'b1, 16'(c), (c % 64) == 0, c == 0, refLuma(16'(c)), "R2");
    end
    for (int i = 0; i < 3; i++)
      step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd0, "R5");

    // R7: reset in mid-stream flushes pixels in flight.
    step(1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, 8'd255, "R3");
    step(1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0, 8'd255, "R3");
    step(1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd0, "R7");
    #1;
    chk(outValid == 0 && outLuma == 0 && outSol == 0, "R7", "async clear",
        int'(outLuma), 0);
    step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd0, "R7");
    step(1'b1, 1'b1, 16'h07E0, 1'b1, 1'b0, 8'd149, "R1");
    for (int i = 0; i < 4; i++)
      step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd0, "R5");

    report();
  end
endmodule